// File: doc/BRIEF.md
# Two-Class Interrupt Steering Controller

This block gathers 32 level-sensitive interrupt request lines and steers each one to one of two processor interrupt outputs: a fast class or a normal class. Software can also raise any of the 32 requests itself. Each raised software bit is ORed with the hardware line at the same position, and the result is the effective request for that position.

The block is controlled through a simple register bus with an address, a write strobe, write data and read data. Reads are combinational from the current address. The enable mask never needs a read-modify-write. Writing ones to the enable-set offset turns on those bits. Writing ones to the enable-clear offset turns them off. A zero data bit leaves the matching enable bit alone at either offset. Three read-only views show the effective requests and how they are routed: the enabled normal-class requests, the enabled fast-class requests, and the raw effective requests.

The two interrupt outputs are registered. Each one rises one clock after any enabled request of its class is present.

Top module: `irqSteer`

## Requirements
- R1: After reset the enable mask, class-select mask and software-request mask are all zero, and both interrupt outputs are 0.
- R2: A write to offset 0x10 sets every enable bit whose data bit is 1 and leaves the others unchanged. A read of 0x10 returns the enable mask.
- R3: A write to offset 0x14 clears every enable bit whose data bit is 1 and leaves the others unchanged. A read of 0x14 returns zero.
- R4: Offset 0x0C holds the class-select mask and can be read and written. A bit value of 1 routes that line to the fast class. A bit value of 0 routes it to the normal class.
- R5: Offset 0x18 holds the software-request mask and can be read and written. The effective request is the hardware line ORed with the software bit, and offset 0x08 reads the effective request vector.
- R6: Offset 0x00 reads, per bit, effective request AND enable AND NOT select.
- R7: Offset 0x04 reads, per bit, effective request AND enable AND select.
- R8: `fastIrq` equals the OR of the fast-class status sampled at the previous rising edge. `normIrq` equals the OR of the normal-class status sampled at the previous rising edge.
- R9: Writes to the status offsets 0x00, 0x04 and 0x08 change no state. Every address other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 reads zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register byte address |
| busWr | input | 1 | Write strobe for the addressed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| reqIn | input | 32 | Hardware request lines, level-sensitive |
| fastIrq | output | 1 | Registered fast-class interrupt |
| normIrq | output | 1 | Registered normal-class interrupt |

## Verification
The main steering function is tried with three kinds of pattern. The first is directed set and clear writes on overlapping masks, which separates write-one-to-set and write-one-to-clear from a plain overwrite. The second is requests that come in only from hardware or only from software, which shows that the two sources are ORed and routed the same way. The third is select masks with alternating bits under identical requests, which shows whether a line lands in the fast view or the normal view. A long pseudo-random run mixes every offset, several unmapped addresses, misaligned addresses and sparse request vectors. It compares read data and both outputs against a behavioural model on every clock, so any one-cycle error in output latency is caught.

// File: rtl/irqSteerPkg.sv
package irqSteerPkg;

  localparam int unsigned OFF_NORM_STAT = 32'h00;
  localparam int unsigned OFF_FAST_STAT = 32'h04;
  localparam int unsigned OFF_RAW_STAT  = 32'h08;
  localparam int unsigned OFF_CLASS_SEL = 32'h0C;
  localparam int unsigned OFF_EN_SET    = 32'h10;
  localparam int unsigned OFF_EN_CLR    = 32'h14;
  localparam int unsigned OFF_SOFT_REQ  = 32'h18;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_NORM,
    RD_FAST,
    RD_RAW,
    RD_SEL,
    RD_EN,
    RD_SOFT
  } rdSel_e;

  typedef struct packed {
    logic   enSet;
    logic   enClr;
    logic   selWr;
    logic   softWr;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irqSteerCtrl.sv
module irqSteerCtrl
  import irqSteerPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    case (busAddr)
      ADDR_W'(OFF_NORM_STAT): strobe.rdSel = RD_NORM;
      ADDR_W'(OFF_FAST_STAT): strobe.rdSel = RD_FAST;
      ADDR_W'(OFF_RAW_STAT):  strobe.rdSel = RD_RAW;
      ADDR_W'(OFF_CLASS_SEL): begin
        strobe.rdSel = RD_SEL;
        strobe.selWr = busWr;
      end
      ADDR_W'(OFF_EN_SET): begin
        strobe.rdSel = RD_EN;
        strobe.enSet = busWr;
      end
      ADDR_W'(OFF_EN_CLR): begin
        strobe.rdSel = RD_NONE;
        strobe.enClr = busWr;
      end
      ADDR_W'(OFF_SOFT_REQ): begin
        strobe.rdSel = RD_SOFT;
        strobe.softWr = busWr;
      end
      default: strobe.rdSel = RD_NONE;
    endcase
  end

  // R9: at most one register is written per bus cycle
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.enSet, strobe.enClr, strobe.selWr, strobe.softWr}));

  // R9: no write strobe fires without a bus write
  p_no_stray_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> !(strobe.enSet || strobe.enClr || strobe.selWr || strobe.softWr));

endmodule

// File: rtl/irqSteerPath.sv
module irqSteerPath
  import irqSteerPkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [NUM_LINES-1:0] busWdata,
  input  logic [NUM_LINES-1:0] reqIn,
  output logic [NUM_LINES-1:0] busRdata,
  output logic                 fastIrq,
  output logic                 normIrq
);

  logic [NUM_LINES-1:0] enMask;
  logic [NUM_LINES-1:0] selMask;
  logic [NUM_LINES-1:0] softMask;
  logic [NUM_LINES-1:0] effReq;
  logic [NUM_LINES-1:0] fastStat;
  logic [NUM_LINES-1:0] normStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask   <= '0;
      selMask  <= '0;
      softMask <= '0;
    end else begin
      if (strobe.enSet)  enMask   <= enMask | busWdata;
      if (strobe.enClr)  enMask   <= enMask & ~busWdata;
      if (strobe.selWr)  selMask  <= busWdata;
      if (strobe.softWr) softMask <= busWdata;
    end
  end

  assign effReq   = reqIn | softMask;
  assign fastStat = effReq & enMask & selMask;
  assign normStat = effReq & enMask & ~selMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastIrq <= 1'b0;
      normIrq <= 1'b0;
    end else begin
      fastIrq <= |fastStat;
      normIrq <= |normStat;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_NORM: busRdata = normStat;
      RD_FAST: busRdata = fastStat;
      RD_RAW:  busRdata = effReq;
      RD_SEL:  busRdata = selMask;
      RD_EN:   busRdata = enMask;
      RD_SOFT: busRdata = softMask;
      default: busRdata = '0;
    endcase
  end

  // R2: every written one is enabled in the next cycle
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enSet |=> ((enMask & $past(busWdata)) == $past(busWdata)));

  // R3: every written one is disabled in the next cycle
  p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enClr |=> ((enMask & $past(busWdata)) == '0));

  // R2/R3: the enable mask only moves on an enable write
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.enSet || strobe.enClr) |=> $stable(enMask));

  // R8: no fast interrupt without an enabled fast-class request one cycle earlier
  p_fast_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((effReq & enMask & selMask) == '0) |=> !fastIrq);

  // R8: no normal interrupt without an enabled normal-class request one cycle earlier
  p_norm_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((effReq & enMask & ~selMask) == '0) |=> !normIrq);

endmodule

// File: rtl/irqSteer.sv
module irqSteer
  import irqSteerPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] reqIn,
  output logic                 fastIrq,
  output logic                 normIrq
);

  regStrobe_t strobe;

  irqSteerCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWr  (busWr),
    .strobe (strobe)
  );

  irqSteerPath #(.NUM_LINES(NUM_LINES)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .reqIn   (reqIn),
    .busRdata(busRdata),
    .fastIrq (fastIrq),
    .normIrq (normIrq)
  );

endmodule

// File: tb/irqSteer_tb.sv
module irqSteer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] reqIn = '0;
  logic        fastIrq;
  logic        normIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [31:0] mEn = '0, mSel = '0, mSoft = '0;
  logic        mFast = 1'b0, mNorm = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqSteer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .reqIn(reqIn),
    .fastIrq(fastIrq), .normIrq(normIrq)
  );

  function automatic logic [31:0] expRead(input logic [7:0] a, input logic [31:0] hw);
    logic [31:0] eff;
    eff = hw | mSoft;
    case (a)
      8'h00:   return eff & mEn & ~mSel;
      8'h04:   return eff & mEn & mSel;
      8'h08:   return eff;
      8'h0C:   return mSel;
      8'h10:   return mEn;
      8'h14:   return 32'h0;
      8'h18:   return mSoft;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    case (a)
      8'h00:   return "R6";
      8'h04:   return "R7";
      8'h08:   return "R5";
      8'h0C:   return "R4";
      8'h10:   return "R2";
      8'h14:   return "R3";
      8'h18:   return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle; inputs are driven and sampled at the falling edge.
  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic [31:0] hw);
    logic [31:0] eff;
    busAddr = a; busWr = w; busWdata = d; reqIn = hw;
    #1;
    check(tagOf(a), busRdata, expRead(a, hw));
    @(posedge clk);
    eff   = hw | mSoft;
    mFast = |(eff & mEn & mSel);
    mNorm = |(eff & mEn & ~mSel);
    if (w) begin
      case (a)
        8'h0C: mSel  = d;
        8'h10: mEn   = mEn | d;
        8'h14: mEn   = mEn & ~d;
        8'h18: mSoft = d;
        default: ;
      endcase
    end
    @(negedge clk);
    check("R8 fastIrq", {31'b0, fastIrq}, {31'b0, mFast});
    check("R8 normIrq", {31'b0, normIrq}, {31'b0, mNorm});
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state through the bus and the outputs
    @(negedge clk);
    reqIn = 32'hFFFF_FFFF;
    foreach (u_dut.busRdata[i]) ; // no-op to keep the loop form unused
    for (int k = 0; k < 7; k++) begin
      busAddr = 8'(k * 4);
      #1;
      if (k >= 3) check("R1 register reset", busRdata, 32'h0);
    end
    check("R1 fastIrq reset", {31'b0, fastIrq}, 32'h0);
    check("R1 normIrq reset", {31'b0, normIrq}, 32'h0);
    reqIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2: set keeps earlier bits
    step(8'h10, 1, 32'h0000_00F0, '0);
    step(8'h10, 1, 32'h0000_0F00, '0);
    step(8'h10, 0, 32'h0, '0);
    // R3: clear only the written ones; alias reads zero
    step(8'h14, 1, 32'h0000_0030, '0);
    step(8'h14, 0, 32'h0, '0);
    step(8'h10, 0, 32'h0, '0);
    // R4: class select, alternating bits
    step(8'h0C, 1, 32'hAAAA_AAAA, '0);
    step(8'h0C, 0, 32'h0, '0);
    // R6/R7/R8: hardware-only requests
    step(8'h00, 0, 32'h0, 32'h0000_0F00);
    step(8'h04, 0, 32'h0, 32'h0000_0F00);
    step(8'h04, 0, 32'h0, 32'h0000_0400);
    step(8'h00, 0, 32'h0, 32'h0000_0100);
    step(8'h08, 0, 32'h0, 32'h8000_0001);
    // R5: software-only requests
    step(8'h18, 1, 32'h0000_0080, '0);
    step(8'h08, 0, 32'h0, '0);
    step(8'h04, 0, 32'h0, '0);
    step(8'h18, 1, 32'h0000_0040, '0);
    step(8'h00, 0, 32'h0, '0);
    // R9: writes to status and unmapped offsets are ignored
    step(8'h00, 1, 32'hFFFF_FFFF, '0);
    step(8'h04, 1, 32'hFFFF_FFFF, '0);
    step(8'h08, 1, 32'hFFFF_FFFF, '0);
    step(8'h1C, 1, 32'hFFFF_FFFF, '0);
    step(8'h12, 1, 32'hFFFF_FFFF, '0);
    step(8'hF0, 1, 32'hFFFF_FFFF, '0);
    step(8'h10, 0, 32'h0, '0);
    step(8'h0C, 0, 32'h0, '0);
    step(8'h18, 0, 32'h0, '0);
    step(8'h1C, 0, 32'h0, 32'hFFFF_FFFF);

    // mixed pseudo-random run over all offsets
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [7:0]  a;
      r = nextRand();
      case (r[3:0])
        4'd8:  a = 8'h1C;
        4'd9:  a = 8'h02;
        4'd10: a = 8'h40;
        default: a = 8'((r[3:0] % 7) * 4);
      endcase
      step(a, r[4], nextRand() & nextRand(), nextRand() & nextRand() & nextRand());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule